// File: doc/BRIEF.md
# Single-Flag Compare and Branch Unit

This unit keeps one true/false condition bit and is the only place in the core that decides conditional branches. A small set of compare and test operations writes the bit. Every other operation, ordinary arithmetic included, leaves it as it was. The two branch operations read only this bit to choose between the branch target and the sequential program counter.

Each operation arrives as an operation code, two register operands, a branch target and the sequential next PC, qualified by a valid strobe. All results are registered and appear one clock after the operation is presented. The condition bit therefore changes on the edge that ends the operation that writes it, and a branch issued in the following cycle sees the new value. A move operation copies the bit out, zero-extended to a register-wide word.

A parameter chooses how the comparisons are built. They can share one subtractor, taking borrow, sign and overflow from it, or each can be a separate magnitude comparator.

Top module: `flag_branch_unit`

## Requirements
- R1: While rst_n is low, and after it is released, t_o, taken_o, next_pc_o and movt_o are all zero until the first valid operation.
- R2: Operation codes are: 0 no-op, 1 add, 2 compare-equal, 3 signed greater-or-equal, 4 signed greater-than, 5 unsigned higher-or-same, 6 unsigned higher, 7 AND test, 8 set flag, 9 clear flag, 10 branch-if-true, 11 branch-if-false, 12 move flag. Codes 13 to 15 behave as a no-op: they leave the flag alone, give taken_o 0 and give next_pc_o equal to seq_pc_i.
- R3: Code 3 sets the flag to 1 when signed rn_i >= signed rm_i and to 0 otherwise. Code 4 sets it to 1 when signed rn_i > signed rm_i and to 0 otherwise.
- R4: Code 5 sets the flag to 1 when unsigned rn_i >= unsigned rm_i and to 0 otherwise. Code 6 sets it to 1 when unsigned rn_i > unsigned rm_i and to 0 otherwise.
- R5: Code 2 sets the flag to 1 when rn_i equals rm_i and to 0 otherwise.
- R6: Code 7 sets the flag to 1 when (rn_i & rm_i) is zero and to 0 otherwise, so testing a value against itself reports whether that value is zero.
- R7: Codes 0, 1, 10, 11 and 12 never change the flag, whatever the operands are. This includes an add of the all-ones value (-1).
- R8: Code 8 sets the flag to 1 and code 9 clears it to 0, whatever the operands are.
- R9: Code 10 is taken when the flag is 1 and code 11 is taken when the flag is 0. A taken branch gives taken_o 1 and gives next_pc_o equal to target_i.
- R10: A branch that is not taken, and any operation that is not a branch, gives taken_o 0 and gives next_pc_o equal to seq_pc_i.
- R11: Code 12 loads movt_o with the flag value, zero-extended to DATA_W bits. Other operations leave movt_o unchanged.
- R12: While valid_i is low, t_o, taken_o, next_pc_o and movt_o hold their values.
- R13: All outputs are registered one cycle after the valid operation. A branch evaluates the flag as it stood before that branch, which includes a write made by the operation in the cycle just before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Qualifies the operation on this cycle |
| op_i | input | 4 | Operation code, see R2 |
| rn_i | input | DATA_W | First operand |
| rm_i | input | DATA_W | Second operand |
| target_i | input | ADDR_W | Branch target address |
| seq_pc_i | input | ADDR_W | Sequential next PC |
| t_o | output | 1 | Condition flag |
| taken_o | output | 1 | Branch taken for the last valid operation |
| next_pc_o | output | ADDR_W | Selected next PC |
| movt_o | output | DATA_W | Flag copied out by the move operation |

## Verification
The bench builds the unit with DATA_W = 8, ADDR_W = 16 and the shared-subtractor comparator. With 8-bit operands, random draws often produce equal operands, operands that differ in sign only, and pairs around 0x7F/0x80. These are the cases where the signed and unsigned comparisons disagree and where the overflow term of the subtractor matters. The narrow widths also make it likely that a random AND test produces zero, so both flag values are seen for every compare variant.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_CMPEQ = 4'd2,
        OP_CMPGE = 4'd3,
        OP_CMPGT = 4'd4,
        OP_CMPHS = 4'd5,
        OP_CMPHI = 4'd6,
        OP_TST   = 4'd7,
        OP_SETT  = 4'd8,
        OP_CLRT  = 4'd9,
        OP_BT    = 4'd10,
        OP_BF    = 4'd11,
        OP_MOVT  = 4'd12
    } cbu_op_e;

    typedef struct packed {
        logic eq;
        logic ge_s;
        logic gt_s;
        logic hs_u;
        logic hi_u;
        logic and_zero;
    } cmp_res_t;

endpackage

// File: rtl/cbu_compare.sv
module cbu_compare
    import cbu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit USE_SUB = 1'b1
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output cmp_res_t          res_o
);
    localparam int MSB = DATA_W - 1;

    logic eq, ge_s, hs_u;

    generate
        if (USE_SUB) begin : g_sub
            logic [DATA_W:0] diff;
            logic            borrow;
            logic            ovf;
            logic            lt_s;
            always_comb begin
                diff   = {1'b0, a_i} - {1'b0, b_i};
                borrow = diff[DATA_W];
                ovf    = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
                lt_s   = diff[MSB] ^ ovf;
                eq     = (diff[MSB:0] == '0);
                hs_u   = !borrow;
                ge_s   = !lt_s;
            end
        end else begin : g_cmp
            always_comb begin
                eq   = (a_i == b_i);
                hs_u = (a_i >= b_i);
                ge_s = ($signed(a_i) >= $signed(b_i));
            end
        end
    endgenerate

    always_comb begin
        res_o.eq       = eq;
        res_o.ge_s     = ge_s;
        res_o.gt_s     = ge_s && !eq;
        res_o.hs_u     = hs_u;
        res_o.hi_u     = hs_u && !eq;
        res_o.and_zero = ((a_i & b_i) == '0);
    end

endmodule

// File: rtl/cbu_flag_sel.sv
module cbu_flag_sel
    import cbu_pkg::*;
(
    input  logic [3:0] op_i,
    input  cmp_res_t   res_i,
    output logic       we_o,
    output logic       val_o
);
    always_comb begin
        we_o  = 1'b1;
        val_o = 1'b0;
        case (op_i)
            OP_CMPEQ: val_o = res_i.eq;
            OP_CMPGE: val_o = res_i.ge_s;
            OP_CMPGT: val_o = res_i.gt_s;
            OP_CMPHS: val_o = res_i.hs_u;
            OP_CMPHI: val_o = res_i.hi_u;
            OP_TST:   val_o = res_i.and_zero;
            OP_SETT:  val_o = 1'b1;
            OP_CLRT:  val_o = 1'b0;
            default:  we_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_branch.sv
module cbu_branch
    import cbu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]        op_i,
    input  logic              t_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] seq_pc_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o
);
    always_comb begin
        case (op_i)
            OP_BT:   taken_o = t_i;
            OP_BF:   taken_o = !t_i;
            default: taken_o = 1'b0;
        endcase
        next_pc_o = taken_o ? target_i : seq_pc_i;
    end

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter bit USE_SUB = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] rn_i,
    input  logic [DATA_W-1:0] rm_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] seq_pc_i,
    output logic              t_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [DATA_W-1:0] movt_o
);
    typedef struct packed {
        logic              t;
        logic              taken;
        logic [ADDR_W-1:0] next_pc;
        logic [DATA_W-1:0] movt;
    } unit_state_t;

    unit_state_t state_d, state_q;

    cmp_res_t          cmp_res;
    logic              flag_we;
    logic              flag_val;
    logic              br_taken;
    logic [ADDR_W-1:0] br_pc;

    cbu_compare #(
        .DATA_W (DATA_W),
        .USE_SUB(USE_SUB)
    ) u_compare (
        .a_i  (rn_i),
        .b_i  (rm_i),
        .res_o(cmp_res)
    );

    cbu_flag_sel u_flag_sel (
        .op_i (op_i),
        .res_i(cmp_res),
        .we_o (flag_we),
        .val_o(flag_val)
    );

    cbu_branch #(
        .ADDR_W(ADDR_W)
    ) u_branch (
        .op_i     (op_i),
        .t_i      (state_q.t),
        .target_i (target_i),
        .seq_pc_i (seq_pc_i),
        .taken_o  (br_taken),
        .next_pc_o(br_pc)
    );

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            if (flag_we) begin
                state_d.t = flag_val;
            end
            state_d.taken   = br_taken;
            state_d.next_pc = br_pc;
            if (op_i == OP_MOVT) begin
                state_d.movt = {{(DATA_W-1){1'b0}}, state_q.t};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign t_o       = state_q.t;
    assign taken_o   = state_q.taken;
    assign next_pc_o = state_q.next_pc;
    assign movt_o    = state_q.movt;

endmodule

// File: rtl/flag_branch_unit_chk.sv
module flag_branch_unit_chk
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] rn_i,
    input logic [DATA_W-1:0] rm_i,
    input logic [ADDR_W-1:0] target_i,
    input logic [ADDR_W-1:0] seq_pc_i,
    input logic              t_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic [DATA_W-1:0] movt_o
);
    logic keeps_flag;
    logic is_branch;
    assign keeps_flag = (op_i == OP_NOP) || (op_i == OP_ADD) || (op_i == OP_BT) ||
                        (op_i == OP_BF) || (op_i == OP_MOVT) || (op_i > 4'd12);
    assign is_branch  = (op_i == OP_BT) || (op_i == OP_BF);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(t_o) && $stable(taken_o) && $stable(next_pc_o) && $stable(movt_o)); // R12

    AST_FLAG_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && keeps_flag) |=> $stable(t_o)); // R7

    AST_SET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_SETT) |=> t_o); // R8

    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_CLRT) |=> !t_o); // R8

    AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_CMPEQ) |=> (t_o == ($past(rn_i) == $past(rm_i)))); // R5

    AST_BT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_BT && t_o) |=> taken_o && (next_pc_o == $past(target_i))); // R9

    AST_BF_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_BF && !t_o) |=> taken_o && (next_pc_o == $past(target_i))); // R9

    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !is_branch) |=> !taken_o && (next_pc_o == $past(seq_pc_i))); // R10

    AST_MOVT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_MOVT) |=> (movt_o == {{(DATA_W-1){1'b0}}, $past(t_o)})); // R11

endmodule

bind flag_branch_unit flag_branch_unit_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .rn_i     (rn_i),
    .rm_i     (rm_i),
    .target_i (target_i),
    .seq_pc_i (seq_pc_i),
    .t_o      (t_o),
    .taken_o  (taken_o),
    .next_pc_o(next_pc_o),
    .movt_o   (movt_o)
);

// File: tb/flag_branch_unit_tb.sv
module flag_branch_unit_tb;
    localparam int W  = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic [W-1:0]  rn_i = '0, rm_i = '0;
    logic [AW-1:0] target_i = '0, seq_pc_i = '0;
    logic          t_o, taken_o;
    logic [AW-1:0] next_pc_o;
    logic [W-1:0]  movt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic          e_t = 1'b0, e_taken = 1'b0;
    logic [AW-1:0] e_pc = '0;
    logic [W-1:0]  e_movt = '0;
    string         e_tag = "R1";

    always #5 clk = ~clk;

    flag_branch_unit #(.DATA_W(W), .ADDR_W(AW), .USE_SUB(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .rn_i(rn_i), .rm_i(rm_i), .target_i(target_i), .seq_pc_i(seq_pc_i),
        .t_o(t_o), .taken_o(taken_o), .next_pc_o(next_pc_o), .movt_o(movt_o)
    );

    function automatic logic [1:0] flag_model(input logic [3:0] op, input logic [W-1:0] a,
                                              input logic [W-1:0] b, input logic t);
        // returns {write, value}
        case (op)
            4'd2:  return {1'b1, a == b};
            4'd3:  return {1'b1, $signed(a) >= $signed(b)};
            4'd4:  return {1'b1, $signed(a) >  $signed(b)};
            4'd5:  return {1'b1, a >= b};
            4'd6:  return {1'b1, a >  b};
            4'd7:  return {1'b1, (a & b) == '0};
            4'd8:  return 2'b11;
            4'd9:  return 2'b10;
            default: return {1'b0, t};
        endcase
    endfunction

    function automatic string tag_of(input logic v, input logic [3:0] op);
        if (!v) return "R12";
        case (op)
            4'd0, 4'd1:        return "R7/R10";
            4'd2:              return "R5";
            4'd3, 4'd4:        return "R3";
            4'd5, 4'd6:        return "R4";
            4'd7:              return "R6";
            4'd8, 4'd9:        return "R8";
            4'd10, 4'd11:      return "R9";
            4'd12:             return "R11";
            default:           return "R2";
        endcase
    endfunction

    task automatic check_outputs();
        checks++;
        if ({t_o, taken_o, next_pc_o, movt_o} !== {e_t, e_taken, e_pc, e_movt}) begin
            fails++;
            $display("FAIL %s: got t=%0b taken=%0b pc=%h movt=%h expected t=%0b taken=%0b pc=%h movt=%h",
                     e_tag, t_o, taken_o, next_pc_o, movt_o, e_t, e_taken, e_pc, e_movt);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [AW-1:0] tgt,
                        input logic [AW-1:0] seq, input string tag);
        logic [1:0] fw;
        logic       tk;
        @(negedge clk);
        check_outputs();
        valid_i = v; op_i = op; rn_i = a; rm_i = b; target_i = tgt; seq_pc_i = seq;
        e_tag = (tag == "") ? tag_of(v, op) : tag;
        if (v) begin
            tk      = (op == 4'd10 && e_t) || (op == 4'd11 && !e_t);
            e_taken = tk;
            e_pc    = tk ? tgt : seq;
            if (op == 4'd12) e_movt = {{(W-1){1'b0}}, e_t};
            fw = flag_model(op, a, b, e_t);
            if (fw[1]) e_t = fw[0];
        end
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        checks++; // R1 during reset
        if ({t_o, taken_o, next_pc_o, movt_o} !== '0) begin
            fails++;
            $display("FAIL R1: got %h expected 0", {t_o, taken_o, next_pc_o, movt_o});
        end
        rst_n = 1'b1;
        step(0, 4'd0, 8'h00, 8'h00, 16'h0, 16'h0, "R1");
        // directed corners
        step(1, 4'd8, 8'h00, 8'h00, 16'h1000, 16'h0002, "");   // R8 set
        step(1, 4'd1, 8'h01, 8'hFF, 16'h1100, 16'h0004, "R7"); // add -1 keeps T
        step(1, 4'd12, 8'h00, 8'h00, 16'h1200, 16'h0006, "");  // R11 movt=1
        step(1, 4'd3, 8'h80, 8'h7F, 16'h1300, 16'h0008, "");   // R3 -128>=127 false
        step(1, 4'd10, 8'h00, 8'h00, 16'h1400, 16'h000A, "R13"); // sees new T=0
        step(1, 4'd5, 8'h80, 8'h7F, 16'h1500, 16'h000C, "");   // R4 unsigned true
        step(1, 4'd10, 8'h00, 8'h00, 16'h1600, 16'h000E, "R13"); // taken
        step(1, 4'd4, 8'h05, 8'h05, 16'h1700, 16'h0010, "");   // R3 gt equal false
        step(1, 4'd6, 8'hFF, 8'hFF, 16'h1800, 16'h0012, "");   // R4 hi equal false
        step(1, 4'd11, 8'h00, 8'h00, 16'h1900, 16'h0014, "");  // R9 bf taken
        step(1, 4'd2, 8'h5A, 8'h5A, 16'h1A00, 16'h0016, "");   // R5
        step(1, 4'd7, 8'h00, 8'h00, 16'h1B00, 16'h0018, "");   // R6 self test zero
        step(1, 4'd7, 8'h40, 8'h40, 16'h1C00, 16'h001A, "");   // R6 nonzero
        step(1, 4'd9, 8'h00, 8'h00, 16'h1D00, 16'h001C, "");   // R8 clear
        step(1, 4'd12, 8'h00, 8'h00, 16'h1E00, 16'h001E, "");  // R11 movt=0
        step(1, 4'd14, 8'h00, 8'h00, 16'h1F00, 16'h0020, "");  // R2 unused code
        step(0, 4'd8, 8'h00, 8'h00, 16'h2000, 16'h0022, "");   // R12 ignored set
        step(0, 4'd10, 8'h00, 8'h00, 16'h2100, 16'h0024, "");  // R12
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 5) != 0, 4'($urandom % 16), W'($urandom), W'($urandom),
                 AW'($urandom), AW'($urandom), "");
        end
        step(0, 4'd0, 8'h00, 8'h00, 16'h0, 16'h0, "");
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule